// File: doc/BRIEF.md
# Serial Master Frame Transfer Sequencer

This block sequences the frames of one transfer issued by a serial bus master. Software, or a higher control layer, loads a frame limit, picks receive-only or transmit operation, optionally turns on the slave handshake, and then pulses a start strobe. The sequencer raises a busy flag and issues one start pulse per frame to an external bit-level shift engine. It then waits for the engine's frame-complete pulse and decides whether to launch the next frame or to end the transfer.

In receive-only operation the transfer ends by itself once the limit value plus one frames have been received. In transmit operation it goes on while the engine reports that another frame is queued. With the handshake on, the sequencer polls a slave-ready line after every frame. It launches the next frame, or completes the transfer, only once the slave reports ready. The slave-ready line is asynchronous and passes through a two-flop synchronizer before it is used. A one-cycle completion pulse marks the return to idle.

Top module: `frame_xfer_seq`

## Requirements
- R1: After reset, `busy_o`, `frame_start_o` and `done_o` are all low.
- R2: A `start_i` sampled high while idle makes `busy_o` high, and `frame_start_o` high for exactly one cycle, in the cycle after that clock edge.
- R3: A `start_i` pulse during a transfer is ignored: the number of frames and the number of completion pulses are unchanged.
- R4: With `rx_only_i`=1 latched at start, the transfer issues exactly `frame_limit_i`+1 frame start pulses and then ends. This holds for a limit of 0 and for the all-ones limit.
- R5: With `rx_only_i`=0, `more_i` is sampled at each frame-complete pulse. When it is 1 another frame follows; when it is 0 the transfer ends after that frame.
- R6: With `hs_en_i`=0 latched at start, `busy_o` falls and `done_o` rises in the cycle right after the clock edge that samples the last `frame_done_i`.
- R7: With `hs_en_i`=1, after each frame completes and while the synchronized slave-ready is low, no further `frame_start_o` is issued, `done_o` stays low and `busy_o` stays high.
- R8: `slave_rdy_i` passes through a two-flop synchronizer. When it rises while the sequencer polls, the resulting frame start or completion appears in the cycle after the third rising clock edge that follows the change.
- R9: `done_o` is a single-cycle pulse, exactly one per transfer, and `busy_o` is low while it is high.
- R10: With the handshake on and slave-ready already high, consecutive frame starts are 3 cycles apart when the engine answers in one cycle. With the handshake off they are 2 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Transfer start strobe |
| rx_only_i | input | 1 | 1: receive-only, ends at limit+1 frames; 0: transmit, ends when `more_i` is low |
| hs_en_i | input | 1 | 1: poll slave-ready after each frame |
| frame_limit_i | input | CNT_W | Frame limit (frames = value + 1 in receive-only operation) |
| more_i | input | 1 | Transmit operation: another frame is queued |
| slave_rdy_i | input | 1 | Asynchronous slave-ready status |
| frame_done_i | input | 1 | Shift engine frame-complete pulse |
| busy_o | output | 1 | Transfer in progress |
| frame_start_o | output | 1 | One-cycle pulse launching a frame |
| done_o | output | 1 | One-cycle transfer completion pulse |

## Verification
The bench builds the block with `CNT_W`=4 and `SYNC_STAGES`=2. The 4-bit limit brings the all-ones case, a 16-frame transfer, within a short run, so the count+1 end point is exercised at the counter's full range without overflow. The two-stage synchronizer fixes the ready-to-effect delay at a known three edges, so the handshake timing can be checked to the exact cycle.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SEND  = 3'd1,
    ST_WAIT  = 3'd2,
    ST_POLL  = 3'd3,
    ST_DONE  = 3'd4
  } seq_state_t;

  // Frames seen so far equal ctr+1 after the current frame; last when
  // the pre-increment count equals the limit (no overflow at all-ones).
  function automatic logic is_last_rx(input logic [31:0] ctr,
                                      input logic [31:0] limit);
    return ctr == limit;
  endfunction

endpackage

// File: rtl/xfer_rdy_sync.sv
module xfer_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/xfer_frame_ctr.sv
module xfer_frame_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic             busy_i,
  input  logic             start_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;

  // R3
  start_busy_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && start_i && !inc_i) |=> $stable(cnt_q));
endmodule

// File: rtl/xfer_seq_fsm.sv
module xfer_seq_fsm
  import xfer_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             rx_only_i,
  input  logic             hs_en_i,
  input  logic [CNT_W-1:0] frame_limit_i,
  input  logic             more_i,
  input  logic             rdy_sync_i,
  input  logic             frame_done_i,
  input  logic [CNT_W-1:0] ctr_i,
  output logic             ctr_clr_o,
  output logic             ctr_inc_o,
  output logic             busy_o,
  output logic             frame_start_o,
  output logic             done_o
);
  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] limit_q;
  logic             rx_q, hs_q, last_q;

  // named internal events
  logic start_acc, frame_end, last_now, poll_ok;

  assign start_acc = (state_q == ST_IDLE) && start_i;
  assign frame_end = (state_q == ST_WAIT) && frame_done_i;
  assign last_now  = rx_q ? is_last_rx(32'(ctr_i), 32'(limit_q)) : !more_i;
  assign poll_ok   = (state_q == ST_POLL) && rdy_sync_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_SEND;
      ST_SEND: state_d = ST_WAIT;
      ST_WAIT: if (frame_done_i) begin
                 if (hs_q)          state_d = ST_POLL;
                 else if (last_now) state_d = ST_DONE;
                 else               state_d = ST_SEND;
               end
      ST_POLL: if (rdy_sync_i) state_d = last_q ? ST_DONE : ST_SEND;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      limit_q <= '0;
      rx_q    <= 1'b0;
      hs_q    <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_acc) begin
        limit_q <= frame_limit_i;
        rx_q    <= rx_only_i;
        hs_q    <= hs_en_i;
        last_q  <= 1'b0;
      end
      if (frame_end) last_q <= last_now;
    end
  end

  assign ctr_clr_o     = start_acc;
  assign ctr_inc_o     = frame_end;
  assign busy_o        = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign frame_start_o = (state_q == ST_SEND);
  assign done_o        = (state_q == ST_DONE);

  // R2
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (busy_o && frame_start_o));

  // R6
  hs_off_quick_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !hs_q && last_now) |=> (!busy_o && done_o));

  // R7
  poll_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_POLL) && !rdy_sync_i) |=> (busy_o && !frame_start_o && !done_o));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R2
  start_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |=> !frame_start_o);
endmodule

// File: rtl/frame_xfer_seq.sv
module frame_xfer_seq #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             rx_only_i,
  input  logic             hs_en_i,
  input  logic [CNT_W-1:0] frame_limit_i,
  input  logic             more_i,
  input  logic             slave_rdy_i,
  input  logic             frame_done_i,
  output logic             busy_o,
  output logic             frame_start_o,
  output logic             done_o
);
  logic             rdy_sync;
  logic             ctr_clr, ctr_inc;
  logic [CNT_W-1:0] ctr;

  xfer_rdy_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (slave_rdy_i),
    .sync_o  (rdy_sync)
  );

  xfer_frame_ctr #(.CNT_W(CNT_W)) i_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (ctr_clr),
    .inc_i   (ctr_inc),
    .busy_i  (busy_o),
    .start_i (start_i),
    .count_o (ctr)
  );

  xfer_seq_fsm #(.CNT_W(CNT_W)) i_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .rx_only_i     (rx_only_i),
    .hs_en_i       (hs_en_i),
    .frame_limit_i (frame_limit_i),
    .more_i        (more_i),
    .rdy_sync_i    (rdy_sync),
    .frame_done_i  (frame_done_i),
    .ctr_i         (ctr),
    .ctr_clr_o     (ctr_clr),
    .ctr_inc_o     (ctr_inc),
    .busy_o        (busy_o),
    .frame_start_o (frame_start_o),
    .done_o        (done_o)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!busy_o && !frame_start_o && !done_o));
endmodule

// File: tb/test_frame_xfer_seq.sv
module test_frame_xfer_seq;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, rx_only_i = 1'b1, hs_en_i = 1'b0, more_i = 1'b0;
  logic slave_rdy_i = 1'b0, frame_done_i = 1'b0;
  logic [CNT_W-1:0] frame_limit_i = '0;
  logic busy_o, frame_start_o, done_o;

  int checks = 0, errors = 0;
  int cyc = 0, n_fs = 0, n_done = 0, last_fs_cyc = 0, last_fd_cyc = 0;
  int done_cyc = 0, last_gap = 0, wait_cnt = 0, lat = 1;

  always #2.5 clk = ~clk;

  frame_xfer_seq #(.CNT_W(CNT_W), .SYNC_STAGES(2)) i_frame_xfer_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rx_only_i(rx_only_i),
    .hs_en_i(hs_en_i), .frame_limit_i(frame_limit_i), .more_i(more_i),
    .slave_rdy_i(slave_rdy_i), .frame_done_i(frame_done_i),
    .busy_o(busy_o), .frame_start_o(frame_start_o), .done_o(done_o));

  // shift engine model and event log, all at the falling edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (frame_done_i) frame_done_i = 1'b0;
    if (frame_start_o) begin
      n_fs = n_fs + 1;
      last_gap = cyc - last_fs_cyc;
      last_fs_cyc = cyc;
      wait_cnt = lat;
    end else if (wait_cnt > 0) begin
      wait_cnt = wait_cnt - 1;
      if (wait_cnt == 0) begin
        frame_done_i = 1'b1;
        last_fd_cyc = cyc;
      end
    end
    if (done_o) begin
      n_done = n_done + 1;
      done_cyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic clear_log();
    n_fs = 0; n_done = 0;
  endtask

  task automatic fire(input logic rx, input logic hs, input int limit);
    @(negedge clk);
    rx_only_i = rx; hs_en_i = hs; frame_limit_i = CNT_W'(limit);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    #1;
  endtask

  task automatic wait_done(input string tag);
    int t = 0;
    while (n_done == 0 && t < 2000) begin step(1); t++; end
    chk(n_done != 0, tag, 0, 1);
    step(3);
  endtask

  task automatic t_reset();
    step(1);
    // R1
    chk(!busy_o && !frame_start_o && !done_o, "R1 reset outputs",
        {busy_o, frame_start_o, done_o}, 0);
  endtask

  task automatic t_rx_basic();
    clear_log(); lat = 1;
    fire(1'b1, 1'b0, 3);
    // R2: busy and frame start in the cycle after the accepting edge
    chk(busy_o && frame_start_o, "R2 busy+start", {busy_o, frame_start_o}, 3);
    wait_done("R4 rx done");
    chk(n_fs == 4, "R4 rx limit 3", n_fs, 4);
    chk(done_cyc == last_fd_cyc + 1, "R6 end timing", done_cyc, last_fd_cyc + 1);
    chk(n_done == 1 && !done_o && !busy_o, "R9 single done", n_done, 1);
    chk(last_gap == 2, "R10 no-hs gap", last_gap, 2);
  endtask

  task automatic t_rx_edges();
    clear_log();
    fire(1'b1, 1'b0, 0);
    wait_done("R4 limit0 done");
    chk(n_fs == 1, "R4 limit 0", n_fs, 1);
    clear_log();
    fire(1'b1, 1'b0, 15);
    wait_done("R4 max done");
    chk(n_fs == 16, "R4 limit max", n_fs, 16);
  endtask

  task automatic t_start_ignored();
    clear_log(); lat = 3;
    fire(1'b1, 1'b0, 2);
    step(4);
    start_i = 1'b1; frame_limit_i = 4'd9;
    step(1);
    start_i = 1'b0;
    wait_done("R3 done");
    chk(n_fs == 3, "R3 frames unchanged", n_fs, 3);
    chk(n_done == 1, "R3 one done", n_done, 1);
    lat = 1;
  endtask

  task automatic t_tx_more();
    int t = 0;
    clear_log(); lat = 4; more_i = 1'b1;
    fire(1'b0, 1'b0, 0);
    while (n_fs < 3 && t < 500) begin step(1); t++; end
    more_i = 1'b0;
    wait_done("R5 done");
    chk(n_fs == 3, "R5 tx frames", n_fs, 3);
    lat = 1;
  endtask

  task automatic t_hs_poll();
    int r;
    clear_log(); lat = 4; slave_rdy_i = 1'b0;
    fire(1'b1, 1'b1, 1);
    step(30);
    chk(n_fs == 1 && busy_o, "R7 hold next frame", n_fs, 1);
    slave_rdy_i = 1'b1; r = cyc;
    step(4);
    chk(n_fs == 2 && last_fs_cyc == r + 3, "R8 resume timing", last_fs_cyc, r + 3);
    slave_rdy_i = 1'b0;
    step(30);
    chk(n_done == 0 && busy_o, "R7 hold completion", n_done, 0);
    slave_rdy_i = 1'b1; r = cyc;
    step(4);
    chk(n_done == 1 && done_cyc == r + 3, "R8 done timing", done_cyc, r + 3);
    step(2);
    chk(!busy_o && !done_o, "R9 idle after hs", busy_o, 0);
    lat = 1;
  endtask

  task automatic t_hs_ready_high();
    clear_log(); lat = 1; slave_rdy_i = 1'b1;
    step(3);
    fire(1'b1, 1'b1, 2);
    wait_done("R10 done");
    chk(n_fs == 3, "R10 frames", n_fs, 3);
    chk(last_gap == 3, "R10 hs gap", last_gap, 3);
    chk(done_cyc == last_fd_cyc + 2, "R10 hs end", done_cyc, last_fd_cyc + 2);
    slave_rdy_i = 1'b0;
  endtask

  initial begin
    fork
      begin
        step(3);
        rst_n = 1'b1;
        t_reset();
        t_rx_basic();
        t_rx_edges();
        t_start_ignored();
        t_tx_more();
        t_hs_poll();
        t_hs_ready_high();
      end
      begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule